// File: doc/BRIEF.md
# Two-Class Round-Robin Channel Arbiter

This block decides which of several channels may use a shared DMA engine. Each channel raises a request line. One control register, reached through a small write/read port, holds three kinds of per-channel setting: an enable bit, a priority-class bit, and a steering bit for channel 0's interrupt.

Enabled channels in the high class share the resource round-robin. Any pending high-class request wins over every enabled channel in the normal class. The normal class is also served round-robin, but only when no high-class request is present. Each class keeps its own record of the channel it granted last. Once a channel is granted, it keeps the grant until it drops its request. The grant is also withdrawn when its enable bit is cleared.

The register has four addresses. A plain write replaces the value. The other three addresses set, clear or toggle the bits that are written as ones. Per-channel interrupt lines are combined into a dedicated output and a shared output. Channel 0 can be routed to either of them.

Top module: `dcra_top`

## Requirements
- R1: After reset the control register reads 0x00000000, the grant output is all zero, and both interrupt outputs are low.
- R2: A write at BASE loads the register. A write at BASE+4 ORs the data in, BASE+8 clears the bits written as one, and BASE+0xC XORs them. Writes to any other address change nothing. A read at any of the four addresses returns the register, and a read elsewhere returns zero.
- R3: Bits 31:17, 15:12 and 7:4 always read as zero, whatever is written to them.
- R4: Register bit n (0..3) enables channel n. Bit 8+n puts channel n in the high class. Bit 16 steers channel 0's interrupt.
- R5: A channel whose enable bit is 0 is never newly granted.
- R6: When the arbiter makes a new decision, if any enabled high-class channel is requesting, the grant goes to a high-class channel.
- R7: Among the requesting high-class channels, the grant goes to the first one found by searching upward, with wrap-around, from the channel after the last high-class channel granted. After reset the search starts at channel 0.
- R8: Normal-class channels follow the same rotation using a separate last-granted record. That record is unaffected by high-class grants.
- R9: The grant is a registered one-hot or all-zero vector. A decision made at a clock edge is visible after that edge. A granted channel keeps the grant for as long as it stays enabled and requesting. When its request drops, a new decision is made at the next edge.
- R10: If the granted channel's enable bit is cleared, the grant is removed at the next clock edge after the clearing write.
- R11: With bit 16 at 0, the dedicated interrupt output follows channel 0's interrupt input, and the shared output is the OR of channels 1..3. With bit 16 at 1, the dedicated output is low and the shared output is the OR of all four channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| req_i | input | 4 | Per-channel request |
| irq_i | input | 4 | Per-channel interrupt input |
| gnt_o | output | 4 | Registered one-hot grant |
| irq_ded_o | output | 1 | Dedicated interrupt output for channel 0 |
| irq_shared_o | output | 1 | Shared interrupt output |

## Verification
A register write and an arbitration decision can happen at the same clock edge. For example, a clear or toggle can remove an enable bit or move a channel between classes while the arbiter is releasing or choosing a grant. The random stimulus issues alias writes while requests are active, so these collisions happen often. A directed case clears the enable of the channel that holds the grant. The bench model decides each edge from the register value that held before the edge and only then applies the write. The design's grant is compared against that result one cycle later.

// File: rtl/dcra_pkg.sv
package dcra_pkg;
   // Sub-address selected by reg_addr[3:2]; the order is fixed behaviour.
   typedef enum logic [1:0] {
      OP_LOAD = 2'd0,
      OP_SET  = 2'd1,
      OP_CLR  = 2'd2,
      OP_TOG  = 2'd3
   } reg_op_e;

   localparam int unsigned CLASS_HI = 0;
   localparam int unsigned CLASS_LO = 1;
   localparam int unsigned NUM_CLASSES = 2;
endpackage

// File: rtl/dcra_ctrl_reg.sv
module dcra_ctrl_reg
   import dcra_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter logic [ADDR_W-1:0] BASE = 'h20,
   parameter logic [DATA_W-1:0] LIVE_MASK = 'h0001_0F0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] ctrl_q
);
   localparam int unsigned SUB_LSB = 2;

   if (BASE[3:0] != 4'h0) begin : g_bad_base
      $error("dcra_ctrl_reg: BASE must be 16-byte aligned");
   end
   if (ADDR_W < 5) begin : g_bad_aw
      $error("dcra_ctrl_reg: ADDR_W too small");
   end

   logic              hit;
   reg_op_e           op;
   logic [DATA_W-1:0] nxt;

   assign hit = (addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]) && (addr[1:0] == 2'b00);
   assign op  = reg_op_e'(addr[SUB_LSB+1:SUB_LSB]);

   always_comb begin
      unique case (op)
         OP_LOAD: nxt = wdata;
         OP_SET:  nxt = ctrl_q | wdata;
         OP_CLR:  nxt = ctrl_q & ~wdata;
         default: nxt = ctrl_q ^ wdata;
      endcase
      nxt = nxt & LIVE_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ctrl_q <= '0;
      else if (wr && hit) ctrl_q <= nxt;
   end

   assign rdata = hit ? ctrl_q : '0;

   // R3: reserved bits never become set
   p_reserved_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit) |=> ((ctrl_q & ~LIVE_MASK) == '0));
   // R2: writes that miss leave the register unchanged
   p_miss_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !hit) |=> (ctrl_q == $past(ctrl_q)));
endmodule

// File: rtl/dcra_rr_pick.sv
module dcra_rr_pick #(
   parameter int unsigned N  = 4,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec,
   input  logic [IW-1:0] last,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int k = 1; k <= int'(N); k++) begin
         int j;
         j = (int'(last) + k) % int'(N);
         if (!any && vec[j]) begin
            any = 1'b1;
            idx = IW'(j);
         end
      end
   end
endmodule

// File: rtl/dcra_arb.sv
module dcra_arb
   import dcra_pkg::*;
#(
   parameter int unsigned N  = 4,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic [N-1:0] en,
   input  logic [N-1:0] hp,
   output logic [N-1:0] gnt_q
);
   if (N < 2) begin : g_bad_n
      $error("dcra_arb: needs at least two channels");
   end

   logic [N-1:0]  elig [NUM_CLASSES];
   logic [IW-1:0] last_q [NUM_CLASSES];
   logic          c_any [NUM_CLASSES];
   logic [IW-1:0] c_idx [NUM_CLASSES];
   logic          keep;
   logic [N-1:0]  gnt_d;

   assign elig[CLASS_HI] = req & en & hp;
   assign elig[CLASS_LO] = req & en & ~hp;
   assign keep = |(gnt_q & req & en);

   for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
      dcra_rr_pick #(.N(N)) u_pick (
         .vec  (elig[c]),
         .last (last_q[c]),
         .any  (c_any[c]),
         .idx  (c_idx[c])
      );
      logic win;
      if (c == CLASS_HI) begin : g_hi
         assign win = c_any[c];
      end else begin : g_lo
         assign win = c_any[c] && !c_any[CLASS_HI];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              last_q[c] <= IW'(N - 1);
         else if (!keep && win)   last_q[c] <= c_idx[c];
      end
   end

   always_comb begin
      gnt_d = '0;
      if (keep)                   gnt_d = gnt_q;
      else if (c_any[CLASS_HI])   gnt_d[c_idx[CLASS_HI]] = 1'b1;
      else if (c_any[CLASS_LO])   gnt_d[c_idx[CLASS_LO]] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gnt_q <= '0;
      else        gnt_q <= gnt_d;
   end

   // R9: grant is one-hot or idle
   p_gnt_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_q));
   // R9: a still-active holder keeps its grant
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      keep |=> (gnt_q == $past(gnt_q)));
   // R5: a new decision never lands on a disabled channel
   p_new_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !keep |=> ((gnt_q & ~$past(en)) == '0));
   // R6: high class wins every fresh decision it competes in
   p_hi_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!keep && |(req & en & hp)) |=> |(gnt_q & $past(hp)));
   // R10: a disabled holder loses the grant at the next edge
   p_drop_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
      |(gnt_q & ~en) |=> ((gnt_q & $past(gnt_q)) == '0));
endmodule

// File: rtl/dcra_irq_route.sv
module dcra_irq_route #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq_in,
   input  logic         merge,
   output logic         irq_ded,
   output logic         irq_shared
);
   assign irq_ded    = irq_in[0] & ~merge;
   assign irq_shared = (|irq_in[N-1:1]) | (irq_in[0] & merge);

   // R11: with steering set the dedicated line stays quiet
   p_ded_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      merge |-> !irq_ded);
   // R11: channel 0 never appears on both lines
   p_no_double_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_in[N-1:1] == '0) |-> !(irq_ded && irq_shared));
endmodule

// File: rtl/dcra_top.sv
module dcra_top
   import dcra_pkg::*;
#(
   parameter int unsigned NUM_CH  = 4,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32,
   parameter logic [ADDR_W-1:0] BASE = 'h20,
   parameter int unsigned EN_LSB  = 0,
   parameter int unsigned HP_LSB  = 8,
   parameter int unsigned STEER_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NUM_CH-1:0] req_i,
   input  logic [NUM_CH-1:0] irq_i,
   output logic [NUM_CH-1:0] gnt_o,
   output logic              irq_ded_o,
   output logic              irq_shared_o
);
   localparam logic [DATA_W-1:0] CH_ONES = {NUM_CH{1'b1}};
   localparam logic [DATA_W-1:0] LIVE_MASK = (CH_ONES << EN_LSB) | (CH_ONES << HP_LSB)
                                             | (DATA_W'(1) << STEER_BIT);

   if (EN_LSB + NUM_CH > HP_LSB) begin : g_bad_fields
      $error("dcra_top: enable and priority fields overlap");
   end
   if (HP_LSB + NUM_CH > STEER_BIT || STEER_BIT >= DATA_W) begin : g_bad_steer
      $error("dcra_top: steering bit misplaced");
   end

   logic [DATA_W-1:0] ctrl;

   dcra_ctrl_reg #(
      .ADDR_W (ADDR_W), .DATA_W (DATA_W), .BASE (BASE), .LIVE_MASK (LIVE_MASK)
   ) u_reg (
      .clk (clk), .rst_n (rst_n), .wr (reg_wr), .addr (reg_addr),
      .wdata (reg_wdata), .rdata (reg_rdata), .ctrl_q (ctrl)
   );

   dcra_arb #(.N (NUM_CH)) u_arb (
      .clk (clk), .rst_n (rst_n), .req (req_i),
      .en (ctrl[EN_LSB +: NUM_CH]), .hp (ctrl[HP_LSB +: NUM_CH]),
      .gnt_q (gnt_o)
   );

   dcra_irq_route #(.N (NUM_CH)) u_irq (
      .clk (clk), .rst_n (rst_n), .irq_in (irq_i), .merge (ctrl[STEER_BIT]),
      .irq_ded (irq_ded_o), .irq_shared (irq_shared_o)
   );
endmodule

// File: tb/dcra_top_tb.sv
module dcra_top_tb;
   localparam logic [7:0] BASE = 8'h20;
   localparam logic [31:0] LIVE = 32'h0001_0F0F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = BASE;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  req_i = '0;
   logic [3:0]  irq_i = '0;
   logic [3:0]  gnt_o;
   logic        irq_ded_o, irq_shared_o;

   int n_vec = 0;
   int n_bad = 0;

   logic [31:0] m_ctrl;
   int          m_gnt;
   int          m_last[2];

   always #2.5 clk = ~clk;

   dcra_top u_dut (
      .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
      .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .req_i (req_i),
      .irq_i (irq_i), .gnt_o (gnt_o), .irq_ded_o (irq_ded_o),
      .irq_shared_o (irq_shared_o)
   );

   function automatic int rr(logic [3:0] v, int last);
      for (int k = 1; k <= 4; k++) begin
         if (v[(last + k) % 4]) return (last + k) % 4;
      end
      return -1;
   endfunction

   function automatic bit hit(logic [7:0] a);
      return (a[7:4] == BASE[7:4]) && (a[1:0] == 2'b00);
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_ctrl = '0; m_gnt = -1; m_last[0] = 3; m_last[1] = 3;
   endtask

   // Edge behaviour: decide with the old register value, then apply the write.
   task automatic model_edge();
      logic [3:0] en, hp, ehi, elo;
      logic [31:0] w;
      int p;
      en = m_ctrl[3:0]; hp = m_ctrl[11:8];
      if (!(m_gnt >= 0 && req_i[m_gnt] && en[m_gnt])) begin
         ehi = req_i & en & hp; elo = req_i & en & ~hp;
         m_gnt = -1;
         if (ehi != 0) begin
            p = rr(ehi, m_last[0]); m_gnt = p; m_last[0] = p;
         end else if (elo != 0) begin
            p = rr(elo, m_last[1]); m_gnt = p; m_last[1] = p;
         end
      end
      if (reg_wr && hit(reg_addr)) begin
         case (reg_addr[3:2])
            2'd0: w = reg_wdata;
            2'd1: w = m_ctrl | reg_wdata;
            2'd2: w = m_ctrl & ~reg_wdata;
            default: w = m_ctrl ^ reg_wdata;
         endcase
         m_ctrl = w & LIVE;
      end
   endtask

   task automatic compare_all(string tag);
      logic [3:0] eg;
      logic ded, shr;
      eg = (m_gnt < 0) ? 4'b0 : 4'(1 << m_gnt);
      check({tag, " grant"}, 32'(gnt_o), 32'(eg));
      check("R2 read", reg_rdata, hit(reg_addr) ? m_ctrl : 32'h0);
      ded = irq_i[0] & ~m_ctrl[16];
      shr = (|irq_i[3:1]) | (irq_i[0] & m_ctrl[16]);
      check("R11 irq", {30'b0, irq_ded_o, irq_shared_o}, {30'b0, ded, shr});
   endtask

   task automatic step(string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all(tag);
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      step("R2");
      reg_wr = 1'b0; reg_addr = BASE;
   endtask

   initial begin
      void'($urandom(32'd1729));
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 ctrl", reg_rdata, 32'h0);
      check("R1 grant", 32'(gnt_o), 32'h0);
      check("R1 irq", {30'b0, irq_ded_o, irq_shared_o}, 32'h0);
      rst_n = 1'b1;

      // R3: reserved bits stay zero
      wr(BASE, 32'hFFFF_FFFF);
      check("R3 reserved", reg_rdata, 32'h0001_0F0F);
      // R2: aliases
      wr(BASE + 8'h8, 32'h0000_0F00);
      check("R2 clear", reg_rdata, 32'h0001_000F);
      wr(BASE + 8'hC, 32'h0001_0003);
      check("R2 toggle", reg_rdata, 32'h0000_000C);
      wr(BASE + 8'h4, 32'h0000_0103);
      check("R2 set", reg_rdata, 32'h0000_010F);
      wr(8'h30, 32'h0);
      reg_addr = BASE; #1;
      check("R2 miss ignored", reg_rdata, 32'h0000_010F);

      // R4/R6: ch0 high, all request -> ch0 wins over normals
      req_i = 4'hF; step("R6");
      check("R6 high wins", 32'(gnt_o), 32'h1);
      req_i = 4'hE; step("R8");
      // R8: normal rotation starts at ch1
      check("R8 normal rr", 32'(gnt_o), 32'h2);
      step("R9"); check("R9 hold", 32'(gnt_o), 32'h2);
      // R10: clear holder's enable
      wr(BASE + 8'h8, 32'h0000_0002);
      step("R10"); check("R10 dropped", 32'(gnt_o), 32'h4);
      // R7: two high channels alternate
      req_i = 4'h0; wr(BASE, 32'h0000_0505); step("R7");
      req_i = 4'h5; step("R7");
      check("R7 first", 32'(gnt_o), 32'h4);
      req_i = 4'h1; step("R7");
      req_i = 4'h5; step("R7");
      check("R7 rotate", 32'(gnt_o), 32'h1);
      // R5: disabled requester never granted
      req_i = 4'h0; wr(BASE, 32'h0000_0001); req_i = 4'h2; step("R5"); step("R5");
      check("R5 disabled", 32'(gnt_o), 32'h0);
      // R11: steering
      irq_i = 4'h1; wr(BASE, 32'h0001_0000); #1;
      check("R11 merged", {30'b0, irq_ded_o, irq_shared_o}, 32'h1);

      // Random phase: writes collide with arbitration
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom_range(0, 9);
         reg_wr = (r < 3);
         reg_addr = (r == 9) ? 8'($urandom_range(0, 255)) : BASE + 8'(4 * $urandom_range(0, 3));
         reg_wdata = $urandom & 32'h0001_0F0F | (32'($urandom_range(0, 1)) << 20);
         if (m_gnt >= 0 && $urandom_range(0, 3) != 0) req_i = $urandom | 4'(1 << m_gnt);
         else req_i = 4'($urandom);
         irq_i = 4'($urandom);
         step("R9");
      end
      reg_wr = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #100000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule